// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital timing control for a successive-approximation converter. It runs on a clock at twice the converter clock rate, so every timing point can fall on a whole or a half converter cycle. It counts the half-cycles of each conversion. It raises a sample-and-hold strobe at the right half-cycle, holds a busy flag for the whole conversion, and pulses a done flag during the final converter cycle. It also produces the converter clock phase and a clock at half that rate. Differential conversions are aligned to this half-rate clock.

A conversion can start in three ways. Software can request it, a rising edge on the trigger input can start it in auto-trigger mode, or free-running mode can chain it straight after the previous one. The length of a conversion and the position of its strobe depend on how it started and on whether the input is single-ended or differential. A validity flag tells downstream logic whether the result of the current conversion can be trusted.

Top module: `adc_conv_seq`

## Requirements
- R1: The first conversion after `en_i` rises is an extended conversion: 50 half-cycles (25 converter cycles) long, with the strobe in half-cycle 27 (counting from 0), and `valid_o` high. This holds whatever the start source and the input type.
- R2: A software-started single-ended conversion that is not the first lasts 26 half-cycles, with the strobe in half-cycle 3.
- R3: In auto mode (`auto_i`=1), a rising edge on `trig_i` while idle starts a conversion in the next cycle. That conversion lasts 27 half-cycles, with the strobe in half-cycle 4. The trigger also resets the converter clock phase, so `adc_clk_o` is 1 in the first half-cycle, and it clears `half_clk_o` to 0.
- R4: A software-started differential conversion whose first half-cycle sees `half_clk_o`=0 lasts 26 half-cycles with the strobe in half-cycle 3. If its first half-cycle sees `half_clk_o`=1, it lasts 28 half-cycles with the strobe in half-cycle 5.
- R5: With `free_i`=1 and `auto_i`=0, the next conversion starts in the half-cycle right after the last one. Every chained differential conversion lasts 28 half-cycles with the strobe in half-cycle 5. Every chained single-ended conversion lasts 26 half-cycles with the strobe in half-cycle 3.
- R6: `valid_o` is set when a conversion starts. It is low only for a trigger-started differential conversion that is not the extended first conversion.
- R7: A software start waits for the converter cycle boundary: it is accepted when `adc_clk_o` is 0 and is remembered until then. Starts and triggers that arrive while `busy_o` is high are ignored.
- R8: `done_o` is high in exactly the last two half-cycles of a conversion, which is one converter cycle. The strobe `sh_o` is high for exactly one half-cycle.
- R9: `en_i`=0 aborts any conversion, so `busy_o` is 0 from the next cycle and `valid_o` clears. It also re-arms the extended first conversion and holds `adc_clk_o`=1 and `half_clk_o`=0.
- R10: While enabled and not reset by a trigger, `adc_clk_o` toggles on every clock and `half_clk_o` toggles on each clock where `adc_clk_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the converter clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable; low aborts and re-arms |
| start_i | input | 1 | Software start request |
| trig_i | input | 1 | Auto-trigger source, rising-edge sensitive |
| auto_i | input | 1 | Auto-trigger mode select |
| free_i | input | 1 | Free-running mode select |
| diff_i | input | 1 | 1 = differential input, 0 = single-ended |
| sh_o | output | 1 | Sample-and-hold strobe, one half-cycle wide |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | High during the final converter cycle |
| valid_o | output | 1 | Result of the current conversion is valid |
| adc_clk_o | output | 1 | Converter clock phase |
| half_clk_o | output | 1 | Half-rate clock used for differential alignment |

## Verification
The assertions rely on a few properties of the inputs. `en_i` and `rst_ni` change only between clock edges. A conversion's length is fixed at its start, so `done_o` can only appear during a busy stretch. Mode inputs may change at any time; the design reads them only at a conversion start. The stimulus drives every input on the falling clock edge. It changes the mode selects only while the sequencer is idle, with one exception: dropping `free_i` to end a chain. The trigger is a one-cycle pulse.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    typedef enum logic [2:0] {
        K_EXT     = 3'd0,
        K_SINGLE  = 3'd1,
        K_TRIG    = 3'd2,
        K_DIFF_HI = 3'd3
    } conv_kind_e;
endpackage

// File: rtl/adcseq_phase.sv
module adcseq_phase (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic clr_i,
    output logic ph_o,
    output logic hr_o
);
    typedef struct packed {
        logic ph;
        logic hr;
    } ph_t;

    ph_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en_i || clr_i) begin
            s_d.ph = 1'b0;
            s_d.hr = 1'b0;
        end else begin
            s_d.ph = ~s_q.ph;
            if (s_q.ph) s_d.hr = ~s_q.hr;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign ph_o = s_q.ph;
    assign hr_o = s_q.hr;
endmodule

// File: rtl/adcseq_profile.sv
module adcseq_profile
    import adcseq_pkg::*;
#(
    parameter int CW       = 6,
    parameter int EXT_LEN  = 50,
    parameter int EXT_SH   = 27,
    parameter int SE_LEN   = 26,
    parameter int SE_SH    = 3,
    parameter int TRG_LEN  = 27,
    parameter int TRG_SH   = 4,
    parameter int DHI_LEN  = 28,
    parameter int DHI_SH   = 5
) (
    input  conv_kind_e        kind_i,
    output logic [CW-1:0]     len_o,
    output logic [CW-1:0]     sh_o
);
    always_comb begin
        unique case (kind_i)
            K_EXT: begin
                len_o = CW'(EXT_LEN);
                sh_o  = CW'(EXT_SH);
            end
            K_TRIG: begin
                len_o = CW'(TRG_LEN);
                sh_o  = CW'(TRG_SH);
            end
            K_DIFF_HI: begin
                len_o = CW'(DHI_LEN);
                sh_o  = CW'(DHI_SH);
            end
            default: begin
                len_o = CW'(SE_LEN);
                sh_o  = CW'(SE_SH);
            end
        endcase
    end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adcseq_pkg::*;
#(
    parameter int EXT_LEN = 50,
    parameter int EXT_SH  = 27,
    parameter int SE_LEN  = 26,
    parameter int SE_SH   = 3,
    parameter int TRG_LEN = 27,
    parameter int TRG_SH  = 4,
    parameter int DHI_LEN = 28,
    parameter int DHI_SH  = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic start_i,
    input  logic trig_i,
    input  logic auto_i,
    input  logic free_i,
    input  logic diff_i,
    output logic sh_o,
    output logic busy_o,
    output logic done_o,
    output logic valid_o,
    output logic adc_clk_o,
    output logic half_clk_o
);
    localparam int            CW  = $clog2(EXT_LEN + 1) + 1;
    localparam logic [CW-1:0] ONE = CW'(1);
    localparam logic [CW-1:0] TWO = CW'(2);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [CW-1:0] len;
        logic [CW-1:0] sh;
        logic          first;
        logic          pend;
        logic          valid;
        logic          trig_prev;
    } seq_t;

    seq_t          s_d, s_q;
    logic          ph, hr;
    logic          presc_clr;
    logic          load;
    logic          new_valid;
    logic          trig_edge;
    conv_kind_e    kind;
    logic [CW-1:0] prof_len, prof_sh;

    adcseq_phase i_phase (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .clr_i  (presc_clr),
        .ph_o   (ph),
        .hr_o   (hr)
    );

    adcseq_profile #(
        .CW      (CW),
        .EXT_LEN (EXT_LEN), .EXT_SH (EXT_SH),
        .SE_LEN  (SE_LEN),  .SE_SH  (SE_SH),
        .TRG_LEN (TRG_LEN), .TRG_SH (TRG_SH),
        .DHI_LEN (DHI_LEN), .DHI_SH (DHI_SH)
    ) i_profile (
        .kind_i (kind),
        .len_o  (prof_len),
        .sh_o   (prof_sh)
    );

    assign trig_edge = auto_i & trig_i & ~s_q.trig_prev;

    always_comb begin
        s_d           = s_q;
        s_d.trig_prev = trig_i;
        presc_clr     = 1'b0;
        load          = 1'b0;
        new_valid     = 1'b1;
        kind          = K_SINGLE;
        if (!en_i) begin
            s_d.busy  = 1'b0;
            s_d.cnt   = '0;
            s_d.first = 1'b1;
            s_d.pend  = 1'b0;
            s_d.valid = 1'b0;
        end else if (s_q.busy) begin
            s_d.pend = 1'b0;
            if (s_q.cnt == s_q.len - ONE) begin
                if (free_i && !auto_i) begin
                    load = 1'b1;
                    kind = diff_i ? K_DIFF_HI : K_SINGLE;
                end else begin
                    s_d.busy = 1'b0;
                end
            end else begin
                s_d.cnt = s_q.cnt + ONE;
            end
        end else if (trig_edge) begin
            load      = 1'b1;
            presc_clr = 1'b1;
            kind      = s_q.first ? K_EXT : K_TRIG;
            new_valid = s_q.first | ~diff_i;
        end else if ((start_i || s_q.pend) && ph) begin
            // the half-rate clock flips on this edge, so its next level is ~hr
            load = 1'b1;
            if (s_q.first)  kind = K_EXT;
            else if (diff_i) kind = hr ? K_SINGLE : K_DIFF_HI;
            else             kind = K_SINGLE;
        end else begin
            s_d.pend = s_q.pend | start_i;
        end
        if (load) begin
            s_d.busy  = 1'b1;
            s_d.cnt   = '0;
            s_d.len   = prof_len;
            s_d.sh    = prof_sh;
            s_d.first = 1'b0;
            s_d.pend  = 1'b0;
            s_d.valid = new_valid;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q       <= '0;
            s_q.first <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o     = s_q.busy;
    assign sh_o       = s_q.busy && (s_q.cnt == s_q.sh);
    assign done_o     = s_q.busy && (s_q.cnt >= s_q.len - TWO);
    assign valid_o    = s_q.valid;
    assign adc_clk_o  = ~ph;
    assign half_clk_o = hr;
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic en_i,
    input logic sh_o,
    input logic busy_o,
    input logic done_o,
    input logic adc_clk_o,
    input logic half_clk_o
);
    // R8: strobe is a single half-cycle pulse
    a_r8_sh_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sh_o |=> !sh_o);

    // R8: done spans two half-cycles unless the block is disabled
    a_r8_done_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |=> (done_o || !$past(en_i)));

    // R8: done only inside a conversion
    a_r8_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> busy_o);

    // R9: disable returns to idle and parks the clocks
    a_r9_disable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!busy_o && adc_clk_o && !half_clk_o));

    // R2: strobe never in the first half-cycle of a conversion
    a_r2_no_early_sh: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> !sh_o);
endmodule

bind adc_conv_seq adcseq_chk i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .sh_o       (sh_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .adc_clk_o  (adc_clk_o),
    .half_clk_o (half_clk_o)
);

// File: tb/test_adc_conv_seq.sv
module test_adc_conv_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, start = 1'b0, trig = 1'b0, auto_m = 1'b0, free_m = 1'b0, diff = 1'b0;
    logic sh_o, busy_o, done_o, valid_o, adc_clk_o, half_clk_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    adc_conv_seq i_adc_conv_seq (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_i(start), .trig_i(trig),
        .auto_i(auto_m), .free_i(free_m), .diff_i(diff),
        .sh_o(sh_o), .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o),
        .adc_clk_o(adc_clk_o), .half_clk_o(half_clk_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference model, in half-cycles
    bit m_busy, m_first = 1, m_pend, m_valid, m_tp, m_ph, m_hr;
    int m_cnt, m_len, m_sh;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_len = 0; m_sh = 0; m_first = 1;
            m_pend = 0; m_valid = 0; m_tp = 0; m_ph = 0; m_hr = 0;
        end else begin
            bit tedge, was_ph, go, nv;
            int nl, ns;
            tedge = auto_m && trig && !m_tp;
            was_ph = m_ph;
            m_tp = trig;
            go = 0; nv = 1; nl = 0; ns = 0;
            if (!en) begin
                m_busy = 0; m_cnt = 0; m_first = 1; m_pend = 0; m_valid = 0; m_ph = 0; m_hr = 0;
            end else begin
                if (!m_busy && tedge) begin m_ph = 0; m_hr = 0; end
                else begin if (was_ph) m_hr = !m_hr; m_ph = !was_ph; end
                if (m_busy) begin
                    m_pend = 0;
                    if (m_cnt == m_len - 1) begin
                        if (free_m && !auto_m) begin go = 1; nl = diff ? 28 : 26; ns = diff ? 5 : 3; end
                        else m_busy = 0;
                    end else m_cnt++;
                end else if (tedge) begin
                    go = 1;
                    if (m_first) begin nl = 50; ns = 27; end
                    else begin nl = 27; ns = 4; nv = !diff; end
                end else if ((start || m_pend) && was_ph) begin
                    go = 1;
                    if (m_first) begin nl = 50; ns = 27; end
                    else if (diff && m_hr) begin nl = 28; ns = 5; end
                    else begin nl = 26; ns = 3; end
                end else if (start) m_pend = 1;
                if (go) begin
                    m_busy = 1; m_cnt = 0; m_len = nl; m_sh = ns;
                    m_first = 0; m_pend = 0; m_valid = nv;
                end
            end
        end
    end

    // compare against model and measure conversions, away from the active edge
    bit p_busy, p_done;
    int idx, last_len, last_sh, drun, last_drun;
    bit first_adc;
    int lens[$];

    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy_o == m_busy, "R7 busy", busy_o, m_busy);
            chk(sh_o == (m_busy && m_cnt == m_sh), "R8 sh", sh_o, m_busy && m_cnt == m_sh);
            chk(done_o == (m_busy && m_cnt >= m_len - 2), "R8 done", done_o, m_busy && m_cnt >= m_len - 2);
            chk(valid_o == m_valid, "R6 valid", valid_o, m_valid);
            chk(half_clk_o == m_hr, "R10 half_clk", half_clk_o, m_hr);
            chk(adc_clk_o == !m_ph, "R10 adc_clk", adc_clk_o, !m_ph);
        end
        if (busy_o) begin
            if (!p_busy || (p_done && !done_o)) begin
                if (p_busy) begin last_len = idx + 1; lens.push_back(idx + 1); end
                idx = 0;
                first_adc = adc_clk_o;
            end else idx++;
            if (sh_o) last_sh = idx;
        end else if (p_busy) begin
            last_len = idx + 1;
            lens.push_back(idx + 1);
        end
        if (done_o) begin drun = p_done ? drun + 1 : 1; last_drun = drun; end
        p_busy = busy_o;
        p_done = done_o;
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1; tick(1); start = 0;
    endtask

    task automatic pulse_trig();
        trig = 1; tick(1); trig = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 8 && !busy_o; i++) tick(1);
        for (int i = 0; i < 400 && busy_o; i++) tick(1);
        tick(1);
    endtask

    initial begin
        tick(4);
        // R9: reset state
        chk(!busy_o && !done_o && !sh_o && !valid_o, "R9 reset idle", busy_o, 0);
        rst_n = 1;
        tick(2);
        en = 1;
        tick(3);
        // R1: extended first conversion
        pulse_start();
        wait_idle();
        chk(last_len == 50, "R1 length", last_len, 50);
        chk(last_sh == 27, "R1 strobe", last_sh, 27);
        chk(last_drun == 2, "R8 done width", last_drun, 2);
        // R2 + R7: single-ended, repeated start ignored while busy
        tick(1);
        pulse_start();
        tick(6);
        pulse_start();
        wait_idle();
        chk(last_len == 26, "R2 length", last_len, 26);
        chk(last_sh == 3, "R2 strobe", last_sh, 3);
        tick(10);
        chk(busy_o == 0, "R7 start while busy ignored", busy_o, 0);
        // R4: differential starts at several phases
        diff = 1;
        begin
            bit saw26, saw28;
            saw26 = 0; saw28 = 0;
            for (int k = 0; k < 6; k++) begin
                tick(k);
                pulse_start();
                wait_idle();
                chk(last_len == 26 || last_len == 28, "R4 length", last_len, 26);
                chk(last_sh == (last_len == 28 ? 5 : 3), "R4 strobe", last_sh, last_len == 28 ? 5 : 3);
                if (last_len == 26) saw26 = 1;
                if (last_len == 28) saw28 = 1;
            end
            chk(saw26 && saw28, "R4 both alignments", {saw26, saw28}, 3);
        end
        // R3 + R6: trigger-started differential
        auto_m = 1;
        tick(3);
        pulse_trig();
        chk(first_adc == 1, "R3 prescaler reset phase", first_adc, 1);
        wait_idle();
        chk(last_len == 27, "R3 length", last_len, 27);
        chk(last_sh == 4, "R3 strobe", last_sh, 4);
        chk(valid_o == 0, "R6 auto diff invalid", valid_o, 0);
        diff = 0;
        tick(2);
        pulse_trig();
        wait_idle();
        chk(valid_o == 1, "R6 auto single valid", valid_o, 1);
        // R6 + R9: re-enable makes the trigger conversion extended and valid
        en = 0; tick(1); en = 1; diff = 1; tick(2);
        pulse_trig();
        wait_idle();
        chk(last_len == 50, "R6 extended after re-enable", last_len, 50);
        chk(valid_o == 1, "R6 extended valid", valid_o, 1);
        // R5: free-running differential chain
        auto_m = 0; free_m = 1;
        lens.delete();
        tick(1);
        pulse_start();
        tick(150);
        free_m = 0;
        wait_idle();
        chk(lens.size() >= 4, "R5 chain count", lens.size(), 4);
        for (int k = 1; k < lens.size(); k++)
            chk(lens[k] == 28, "R5 chained diff length", lens[k], 28);
        // R9: abort and re-arm
        diff = 0;
        pulse_start();
        tick(8);
        en = 0; tick(1);
        chk(busy_o == 0, "R9 abort", busy_o, 0);
        en = 1; tick(1);
        pulse_start();
        wait_idle();
        chk(last_len == 50, "R9 re-armed extended", last_len, 50);
        tick(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule